// File: doc/BRIEF.md
# Two-Way Latch/Register Bus Transceiver

This block passes data without inversion between two 18-bit buses, A and B. Each direction has one storage element, and that element works in one of two ways. While its latch enable is high it is a transparent latch, so the far bus follows the near bus. While the latch enable is low it is a register that stores on a falling edge of its capture strobe. Each direction also has an output enable. The A-to-B enable is active high and the B-to-A enable is active low.

The block runs on one system clock, and the latch-enable and strobe inputs are synchronous signals. The strobe passes through one register stage. A falling edge is seen when that registered copy is 1 and the live strobe is 0, and the value on the source bus in that cycle is stored at the clock edge. The block has no tristate pins. Each output is a data word plus a per-bit drive-enable word. A board-level wrapper, or the bus fabric, turns that pair into real bus drive. Storage keeps working while the outputs are released, so a word can be captured first and presented later.

Top module: `bus_xcvr_sync`

## Requirements
- R1: The data path is W = 18 bits in each direction, and bit n of the source bus appears unchanged on bit n of the destination data output.
- R2: While `ab_le` is 1, `b_dat` equals `a_in` in the same cycle, and the A-to-B storage takes `a_in` at every clock edge.
- R3: When `ab_le` goes from 1 to 0, `b_dat` keeps the value `a_in` had in the last cycle in which `ab_le` was 1.
- R4: While `ab_le` is 0, a cycle in which `ab_cp` is 0 and `ab_cp` was 1 at the previous clock edge stores that cycle's `a_in`, and `b_dat` shows it from the next clock edge on.
- R5: While `ab_le` is 0 and `ab_cp` has no falling edge (steady 0, steady 1, or a rising edge), the stored value and `b_dat` stay unchanged whatever `a_in` does.
- R6: `ab_oe` is active high. When it is 1, every bit of `b_drv` is 1, and when it is 0, every bit of `b_drv` is 0.
- R7: The B-to-A direction follows rules R2 to R5 using `ba_le`, `ba_cp`, `b_in` and `a_dat`.
- R8: `ba_oe_n` is active low. When it is 0, every bit of `a_drv` is 1, and when it is 1, every bit of `a_drv` is 0.
- R9: Storage in both directions updates while the outputs are released, and enabling the output later presents the stored word.
- R10: A synchronous `rst` clears both storage words to 0. After reset, with the latch enables at 0, both data outputs read 0, and the drive-enables follow only the output-enable inputs.
- R11: If the latch enable is 1 in the same cycle as a strobe falling edge, transparent mode wins: the output follows the input and the storage tracks it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | 18 | Value sensed on bus A |
| b_in | input | 18 | Value sensed on bus B |
| ab_oe | input | 1 | A-to-B output enable, active high |
| ab_le | input | 1 | A-to-B latch enable |
| ab_cp | input | 1 | A-to-B capture strobe, falling edge stores |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| ba_le | input | 1 | B-to-A latch enable |
| ba_cp | input | 1 | B-to-A capture strobe, falling edge stores |
| b_dat | output | 18 | Word presented toward bus B |
| b_drv | output | 18 | Per-bit drive enable for bus B |
| a_dat | output | 18 | Word presented toward bus A |
| a_drv | output | 18 | Per-bit drive enable for bus A |

## Verification
In one cycle a strobe falling edge can arrive while the latch enable is high. A falling edge can also arrive while the output is released. The bench produces both cases by sweeping all combinations of latch enable, strobe and output enable over consecutive cycles in each direction, with a fresh data word in every cycle. It compares each output against a model built from the mode rules. For the coincident edge, the result is judged from the output in that cycle. It is judged again in the following cycles, once the latch enable has dropped and the stored word must be the last one tracked.

// File: rtl/bus_xcvr_sync.sv
module bus_xcvr_sync #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         ab_oe,
  input  logic         ab_le,
  input  logic         ab_cp,
  input  logic         ba_oe_n,
  input  logic         ba_le,
  input  logic         ba_cp,
  output logic [W-1:0] b_dat,
  output logic [W-1:0] b_drv,
  output logic [W-1:0] a_dat,
  output logic [W-1:0] a_drv
);

  logic [W-1:0] st_ab, st_ba;
  logic         cpq_ab, cpq_ba;
  logic         fall_ab, fall_ba;

  assign fall_ab = cpq_ab & ~ab_cp;
  assign fall_ba = cpq_ba & ~ba_cp;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_ab  <= '0;
      cpq_ab <= 1'b0;
    end else begin
      cpq_ab <= ab_cp;
      if (ab_le || fall_ab) st_ab <= a_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_ba  <= '0;
      cpq_ba <= 1'b0;
    end else begin
      cpq_ba <= ba_cp;
      if (ba_le || fall_ba) st_ba <= b_in;
    end
  end

  assign b_dat = ab_le ? a_in : st_ab;
  assign a_dat = ba_le ? b_in : st_ba;
  assign b_drv = {W{ab_oe}};
  assign a_drv = {W{~ba_oe_n}};

  // R2 / R11: transparent storage tracks the source
  p_track_ab_r2: assert property (@(posedge clk) disable iff (rst)
    ab_le |=> st_ab == $past(a_in));
  p_track_ba_r7: assert property (@(posedge clk) disable iff (rst)
    ba_le |=> st_ba == $past(b_in));

  // R3: output after the enable drops holds the last tracked word
  p_lefall_ab_r3: assert property (@(posedge clk) disable iff (rst)
    (ab_le && !rst) |=> (!ab_le -> b_dat == $past(a_in)));

  // R4: falling strobe with latch closed stores the source
  p_cap_ab_r4: assert property (@(posedge clk) disable iff (rst)
    (!ab_le && cpq_ab && !ab_cp) |=> st_ab == $past(a_in));
  p_cap_ba_r7: assert property (@(posedge clk) disable iff (rst)
    (!ba_le && cpq_ba && !ba_cp) |=> st_ba == $past(b_in));

  // R5: no falling strobe, latch closed: storage holds
  p_hold_ab_r5: assert property (@(posedge clk) disable iff (rst)
    (!ab_le && !(cpq_ab && !ab_cp)) |=> $stable(st_ab));
  p_hold_ba_r7: assert property (@(posedge clk) disable iff (rst)
    (!ba_le && !(cpq_ba && !ba_cp)) |=> $stable(st_ba));

  // R10: reset clears storage
  p_rst_clear_r10: assert property (@(posedge clk)
    rst |=> (st_ab == '0 && st_ba == '0));

endmodule

// File: tb/bus_xcvr_sync_tb.sv
module bus_xcvr_sync_tb_top;
  localparam int W = 18;
  localparam time TCLK = 10ns;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic ab_oe = 1'b0, ab_le = 1'b0, ab_cp = 1'b0;
  logic ba_oe_n = 1'b1, ba_le = 1'b0, ba_cp = 1'b0;
  logic [W-1:0] b_dat, b_drv, a_dat, a_drv;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;
  logic [W-1:0] mst [2];
  bit mcp [2];

  always #(TCLK/2) clk = ~clk;

  bus_xcvr_sync #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in),
    .ab_oe(ab_oe), .ab_le(ab_le), .ab_cp(ab_cp),
    .ba_oe_n(ba_oe_n), .ba_le(ba_le), .ba_cp(ba_cp),
    .b_dat(b_dat), .b_drv(b_drv), .a_dat(a_dat), .a_drv(a_drv));

  task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic step(input bit dir, input bit le, input bit cp, input bit oe,
                      input logic [W-1:0] d, input string tag);
    logic [W-1:0] exp;
    bit fall;
    @(negedge clk);
    if (!dir) begin ab_le = le; ab_cp = cp; ab_oe = oe; a_in = d; end
    else begin ba_le = le; ba_cp = cp; ba_oe_n = ~oe; b_in = d; end
    fall = mcp[dir] && !cp;
    if (le || fall) mst[dir] = d;
    mcp[dir] = cp;
    exp = le ? d : mst[dir];
    @(posedge clk); #1;
    check($sformatf("%s dir%0d data", tag, dir), dir ? a_dat : b_dat, exp);
    check($sformatf("%s dir%0d drive", tag, dir ? "R8" : "R6"), dir ? a_drv : b_drv, {W{oe}});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    mst[0] = '0; mst[1] = '0; mcp[0] = 0; mcp[1] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0; ab_oe = 1'b1; ba_oe_n = 1'b1;
    a_in = 18'h3FFFF; b_in = 18'h2AAAA;
    @(posedge clk); #1;
    check("R10 reset b_dat", b_dat, '0);
    check("R10 reset a_dat", a_dat, '0);
    check("R10 reset b_drv follows oe", b_drv, {W{1'b1}});
    check("R10 reset a_drv follows oe_n", a_drv, '0);

    for (int dir = 0; dir < 2; dir++) begin
      step(dir[0], 1, 0, 1, 18'h00001, "R1 R2 transparent bit0");
      step(dir[0], 1, 0, 1, 18'h20000, "R1 R2 transparent bit17");
      step(dir[0], 1, 0, 1, 18'h15A5A, "R2 R7 transparent");
      step(dir[0], 0, 0, 1, 18'h0F0F0, "R3 R7 le fall holds last");
      step(dir[0], 0, 0, 1, 18'h33333, "R5 R7 steady low ignores");
      step(dir[0], 0, 1, 1, 18'h11111, "R5 R7 rising ignores");
      step(dir[0], 0, 1, 1, 18'h22222, "R5 R7 steady high ignores");
      step(dir[0], 0, 0, 0, 18'h3C3C3, "R4 R9 capture while released");
      step(dir[0], 0, 0, 1, 18'h01234, "R9 R7 enable shows stored");
      step(dir[0], 0, 1, 1, 18'h05555, "R5 R7 prepare strobe");
      step(dir[0], 1, 0, 1, 18'h2DEAD, "R11 le with strobe fall");
      step(dir[0], 0, 0, 1, 18'h0BEEF, "R11 R3 tracked word kept");
      for (int i = 0; i < 512; i++) begin
        logic [W-1:0] d;
        string t;
        d = W'((i * 18'h1357) ^ (i << 7) ^ 18'h2A5A5);
        if (i[0]) t = "R2 R7 sweep transparent";
        else if (mcp[dir] && !i[1]) t = "R4 R7 sweep capture";
        else t = "R5 R7 sweep hold";
        step(dir[0], i[0], i[1], i[2] ^ i[4], d, t);
      end
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule